// File: doc/BRIEF.md
# Clock Timer with BCD Seconds

This block keeps wall-clock time for a chip. It runs in the system clock domain and takes a one-cycle strobe that marks each falling edge of a 256 Hz reference. While the timer runs, each strobe advances an 8-bit divider. Fixed bits of the divider give 32 Hz, 8 Hz, 2 Hz and 1 Hz square waves. When the 1 Hz wave falls, a two-digit BCD seconds counter steps. On its way from 59 back to 00 it raises a one-cycle overflow pulse, so the pulse comes once a minute.

Software starts and stops the timer with a control write, and can load the seconds counter with a BCD value. A start or stop request does not act at once. The next reference strobe applies it, so the divider counts once more after a stop request. The status output stays high until the timer has really halted. A loaded seconds value is used only once. It is not stored, and after a wrap the counter continues from 00.

Top module: `rtc_sec_timer`

## Requirements
- R1: A control write is held as a pending request, and the first `tick_i` strobe after the write cycle applies it. A strobe that falls in the same cycle as the write applies the previous request.
- R2: The strobe that applies a stop request advances the divider once more, and the divider then holds. The strobe that applies a start request does not advance the divider. Strobes while stopped leave it unchanged.
- R3: While running, each `tick_i` strobe adds one to `div_o`, modulo 256. In cycles without a strobe, `div_o` holds its value.
- R4: `run_status_o` is 1 from the cycle after a start write. After a stop write it stays 1 until the strobe that halts the divider, and it is 0 from the cycle after that strobe.
- R5: `taps_o[0]`, `taps_o[1]`, `taps_o[2]` and `taps_o[3]` equal `div_o` bits 2, 4, 6 and 7. These give 32 Hz, 8 Hz, 2 Hz and 1 Hz.
- R6: When `div_o` steps from FFh to 00h, `sec_o` advances one second in BCD, with tens in bits 7:4 and units in bits 3:0. From 59h it goes to 00h, and `sec_ovf_o` is 1 for exactly the one cycle in which 00h first shows.
- R7: A preset write loads `preset_i` into `sec_o` in the next cycle. The value is not kept: after the next wrap the counter reads 00h.
- R8: A preset code whose units digit is above 9 or whose tens digit is above 5 loads 00h.
- R9: If a preset write and a seconds advance fall in the same cycle, the preset wins and no overflow pulse occurs.
- R10: After reset the divider and seconds are 00h, the timer is stopped, and `run_status_o` and `sec_ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe at each 256 Hz falling edge |
| run_wr_i | input | 1 | Write strobe for the run/stop control |
| run_wdata_i | input | 1 | Requested state: 1 run, 0 stop |
| preset_wr_i | input | 1 | Write strobe for the seconds preset |
| preset_i | input | 8 | BCD seconds value to load |
| run_status_o | output | 1 | 1 while running or while a start/stop is still pending |
| div_o | output | 8 | Divider count |
| taps_o | output | 4 | 32, 8, 2, 1 Hz taps (bit 0 to bit 3) |
| sec_o | output | 8 | BCD seconds, 00h to 59h |
| sec_ovf_o | output | 1 | One-cycle pulse on the 59 to 00 wrap |

## Verification
The assertions assume that every input is synchronous to `clk` and steady around the rising edge. They also assume that `tick_i` may be high in any cycle, including back to back, and that preset codes may take any 8-bit value. The seconds range check therefore depends on the clamp, not on the stimulus. The bench drives all inputs on the falling clock edge. It gives strobes with and without idle gaps, lets writes coincide with strobes, and deliberately loads out-of-range codes. It also lines up a preset with the exact strobe that would otherwise wrap 59 to 00.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd2_t;

  localparam bcd2_t SEC_LAST = 8'h59;
  localparam bcd2_t SEC_ZERO = 8'h00;

  // a legal seconds code has units 0..9 and tens 0..5
  function automatic logic bcd_sec_ok(input bcd2_t v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd5);
  endfunction

  // illegal codes collapse to zero so the counter cannot wander off
  function automatic bcd2_t bcd_sec_clamp(input bcd2_t v);
    return bcd_sec_ok(v) ? v : SEC_ZERO;
  endfunction

  // plain BCD increment without the minute wrap
  function automatic bcd2_t bcd_step(input bcd2_t v);
    bcd2_t r;
    if (v[3:0] == 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_run_sync.sv
module rtc_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic active_o,
  output logic status_o
);
  logic req_q;
  logic act_q;

  // pending request: latest software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    req_q <= 1'b0;
    else if (wr_i) req_q <= wdata_i;
  end

  // actual run state follows the request only at a reference strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (tick_i) act_q <= req_q;
  end

  assign active_o = act_q;
  assign status_o = req_q | act_q;
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int W        = 8,
  parameter int FALL_BIT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         fall_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         low_full;

  // the watched bit drops on an increment exactly when it and all below are 1
  assign low_full = &cnt_q[FALL_BIT:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o  = cnt_q;
  assign fall_o = step_i & low_full;
endmodule

// File: rtl/rtc_bcd_sec.sv
module rtc_bcd_sec
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  load_i,
  input  bcd2_t load_val_i,
  output bcd2_t sec_o,
  output logic  ovf_o
);
  bcd2_t sec_q;
  bcd2_t sec_d;
  logic  ovf_q;
  logic  wrap;

  assign wrap = adv_i & ~load_i & (sec_q == SEC_LAST);

  always_comb begin
    sec_d = sec_q;
    if (load_i)        sec_d = bcd_sec_clamp(load_val_i);
    else if (adv_i)    sec_d = (sec_q == SEC_LAST) ? SEC_ZERO : bcd_step(sec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= SEC_ZERO;
      ovf_q <= 1'b0;
    end else begin
      sec_q <= sec_d;
      ovf_q <= wrap;
    end
  end

  assign sec_o = sec_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/rtc_sec_timer.sv
module rtc_sec_timer
  import rtc_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int TAP32_BIT = 2,
  parameter int TAP8_BIT  = 4,
  parameter int TAP2_BIT  = 6,
  parameter int TAP1_BIT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_wr_i,
  input  logic             run_wdata_i,
  input  logic             preset_wr_i,
  input  logic [7:0]       preset_i,
  output logic             run_status_o,
  output logic [DIV_W-1:0] div_o,
  output logic [3:0]       taps_o,
  output logic [7:0]       sec_o,
  output logic             sec_ovf_o
);
  localparam int NUM_TAPS = 4;
  localparam int TapPos [NUM_TAPS] = '{TAP32_BIT, TAP8_BIT, TAP2_BIT, TAP1_BIT};

  // named internal events, visible to the bound checker
  logic run_active;
  logic div_step;
  logic sec_adv;

  rtc_run_sync u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .wr_i     (run_wr_i),
    .wdata_i  (run_wdata_i),
    .active_o (run_active),
    .status_o (run_status_o)
  );

  assign div_step = tick_i & run_active;

  rtc_divider #(
    .W        (DIV_W),
    .FALL_BIT (TAP1_BIT)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (div_step),
    .cnt_o  (div_o),
    .fall_o (sec_adv)
  );

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign taps_o[g] = div_o[TapPos[g]];
  end

  rtc_bcd_sec u_sec (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (sec_adv),
    .load_i     (preset_wr_i),
    .load_val_i (preset_i),
    .sec_o      (sec_o),
    .ovf_o      (sec_ovf_o)
  );
endmodule

// File: rtl/rtc_sec_timer_chk.sv
module rtc_sec_timer_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             preset_wr_i,
  input logic             run_status_o,
  input logic [DIV_W-1:0] div_o,
  input logic [7:0]       sec_o,
  input logic             sec_ovf_o,
  input logic             run_active,
  input logic             div_step
);
  AST_ACTIVE_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(run_active)); // R1

  AST_DIV_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !div_step |=> $stable(div_o)); // R2

  AST_DIV_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    div_step |=> (div_o == DIV_W'($past(div_o) + DIV_W'(1)))); // R3

  AST_STATUS_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |-> run_status_o); // R4

  AST_OVF_SHOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ovf_o |-> (sec_o == 8'h00)); // R6

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ovf_o |=> !sec_ovf_o); // R6

  AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[3:0] <= 4'd9) && (sec_o[7:4] <= 4'd5)); // R8

  AST_PRESET_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    preset_wr_i |=> !sec_ovf_o); // R9
endmodule

bind rtc_sec_timer rtc_sec_timer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .preset_wr_i  (preset_wr_i),
  .run_status_o (run_status_o),
  .div_o        (div_o),
  .sec_o        (sec_o),
  .sec_ovf_o    (sec_ovf_o),
  .run_active   (run_active),
  .div_step     (div_step)
);

// File: tb/rtc_sec_timer_tb.sv
module rtc_sec_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       run_wr_i = 1'b0;
  logic       run_wdata_i = 1'b0;
  logic       preset_wr_i = 1'b0;
  logic [7:0] preset_i = 8'h00;
  logic       run_status_o;
  logic [7:0] div_o;
  logic [3:0] taps_o;
  logic [7:0] sec_o;
  logic       sec_ovf_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_sec_timer u_dut (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i),
    .run_wr_i (run_wr_i), .run_wdata_i (run_wdata_i),
    .preset_wr_i (preset_wr_i), .preset_i (preset_i),
    .run_status_o (run_status_o), .div_o (div_o), .taps_o (taps_o),
    .sec_o (sec_o), .sec_ovf_o (sec_ovf_o)
  );

  typedef struct {
    int         due;
    string      tag;
    logic [7:0] div;
    logic [7:0] sec;
    logic       st;
    logic       ovf;
  } item_t;

  item_t q[$];

  // bench model state
  bit       m_req = 0;
  bit       m_act = 0;
  bit [7:0] m_div = 0;
  bit [7:0] m_sec = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit legal_sec(input bit [7:0] v);
    int t = int'(v[7:4]);
    int o = int'(v[3:0]);
    return (o < 10) && (t < 6);
  endfunction

  function automatic bit [7:0] next_sec(input bit [7:0] v);
    int s = int'(v[7:4]) * 10 + int'(v[3:0]) + 1;
    return {4'(s / 10), 4'(s % 10)};
  endfunction

  // monitor: compare every expected item once its cycle has come
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      bit bad;
      logic [3:0] etap;
      it = q.pop_front();
      etap = {it.div[7], it.div[6], it.div[4], it.div[2]};
      bad = 0;
      checks++;
      if (div_o !== it.div) begin
        $display("FAIL %s div actual=%h expected=%h", it.tag, div_o, it.div); bad = 1;
      end
      if (sec_o !== it.sec) begin
        $display("FAIL %s sec actual=%h expected=%h", it.tag, sec_o, it.sec); bad = 1;
      end
      if (run_status_o !== it.st) begin
        $display("FAIL %s status actual=%b expected=%b", it.tag, run_status_o, it.st); bad = 1;
      end
      if (sec_ovf_o !== it.ovf) begin
        $display("FAIL %s ovf actual=%b expected=%b", it.tag, sec_ovf_o, it.ovf); bad = 1;
      end
      if (taps_o !== etap) begin  // R5 tap positions
        $display("FAIL R5 taps actual=%b expected=%b", taps_o, etap); bad = 1;
      end
      if (bad) failures++;
    end
  end

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input bit tk, input bit rw, input bit rd,
                      input bit pw, input bit [7:0] pd, input string tag);
    item_t it;
    bit adv, ovf, nreq, nact;
    bit [7:0] ndiv, nsec;
    tick_i = tk; run_wr_i = rw; run_wdata_i = rd; preset_wr_i = pw; preset_i = pd;
    adv  = tk && m_act && (m_div == 8'hFF);
    ndiv = (tk && m_act) ? m_div + 8'd1 : m_div;
    nact = tk ? m_req : m_act;
    nreq = rw ? rd : m_req;
    ovf  = 0;
    nsec = m_sec;
    if (pw) nsec = legal_sec(pd) ? pd : 8'h00;
    else if (adv) begin
      if (m_sec == 8'h59) begin nsec = 8'h00; ovf = 1; end
      else nsec = next_sec(m_sec);
    end
    it.due = cyc + 1; it.tag = tag;
    it.div = ndiv; it.sec = nsec; it.st = nreq | nact; it.ovf = ovf;
    q.push_back(it);
    m_req = nreq; m_act = nact; m_div = ndiv; m_sec = nsec;
    @(negedge clk);
    tick_i = 0; run_wr_i = 0; run_wdata_i = 0; preset_wr_i = 0; preset_i = 8'h00;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (div_o !== 8'h00 || sec_o !== 8'h00 || run_status_o !== 1'b0 || sec_ovf_o !== 1'b0) begin
      failures++;
      $display("FAIL R10 actual=%h/%h/%b/%b expected=00/00/0/0", div_o, sec_o, run_status_o, sec_ovf_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    ticks(3, "R2");                          // stopped: strobes ignored
    step(0, 1, 1, 0, 8'h00, "R4");           // start request: status up at once
    step(0, 0, 0, 0, 8'h00, "R4");
    step(1, 0, 0, 0, 8'h00, "R2");           // applying strobe: no count
    ticks(4, "R3");
    for (int i = 0; i < 6; i++) begin        // strobes with idle gaps
      step(0, 0, 0, 0, 8'h00, "R3");
      step(0, 0, 0, 0, 8'h00, "R3");
      step(1, 0, 0, 0, 8'h00, "R3");
    end
    step(1, 1, 0, 0, 8'h00, "R1");           // stop write on a strobe: old request still rules
    step(0, 0, 0, 0, 8'h00, "R4");           // still reads running
    step(1, 0, 0, 0, 8'h00, "R2");           // one more count, then halted
    ticks(3, "R2");
    step(0, 1, 1, 0, 8'h00, "R1");
    step(1, 0, 0, 0, 8'h00, "R1");
    ticks(40, "R3");

    step(0, 0, 0, 1, 8'h58, "R7");           // preset 58
    ticks(520, "R6");                        // through 59 and the wrap to 00
    step(0, 0, 0, 1, 8'h5A, "R8");
    step(0, 0, 0, 1, 8'h60, "R8");
    step(0, 0, 0, 1, 8'hF3, "R8");
    step(0, 0, 0, 1, 8'h37, "R7");

    step(0, 0, 0, 1, 8'h59, "R9");
    while (m_div != 8'hFF) step(1, 0, 0, 0, 8'h00, "R9");
    step(1, 0, 0, 1, 8'h59, "R9");           // preset and wrap collide
    step(0, 0, 0, 0, 8'h00, "R9");
    ticks(260, "R6");                        // natural wrap follows

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule